// File: doc/BRIEF.md
# Configurable Mux-Register I/O Cell

This block is one programmable pad cell for a bus-switching fabric. A 4:1 multiplexer picks one of four lanes of a routing bus, and the result goes both back to the routing side (so several cells can be cascaded into wider multiplexers) and to an output storage element that drives the pad. A second storage element captures pad data on its way into the fabric. A third one times the output enable, whose source is one of two local enables or one of several global enables.

Every storage element is set up by static configuration bits. It can be an edge flop or a transparent latch. It has an initial value of all ones or all zeros, and programmable polarity for its clock, clock enable and set/reset. The data paths can skip their element altogether. The output and enable elements share one clock and enable, and the input element has its own. Left and right neighbour ports let a row of cells form shift registers that run either way, on the input side and on the output side.

Top module: `mrio_cell`

## Requirements
- R1: `mux_fb` equals lane `msel` of `route_in`, where lane k occupies bits [k*DW +: DW]. It changes combinationally.
- R2: In flop mode, an element loads only on the active edge of its clock while its clock enable is active. Otherwise it keeps its value; the output element loads the mux result when its mode is 00.
- R3: In latch mode, an element follows its data while its clock is at the active level and its enable is active. It holds while the clock is at the other level.
- R4: `cfg_byp_out`=1 makes `pad_out` follow `mux_fb` combinationally, and `cfg_byp_in`=1 makes `in_data` follow `pad_in` combinationally. The stored values are left unchanged.
- R5: A polarity bit of 1 makes the clock active on its falling edge (or low level), the clock enable active low, and set/reset active low.
- R6: An active set/reset forces its elements at once, with no clock, to all ones if the element's `cfg_init` bit is 1 and to all zeros if it is 0 (bit 0 input, bit 1 output, bit 2 enable). It overrides the clock enable. A low `grst_n` does the same to all three elements.
- R7: `cfg_out_inv`=1 inverts every bit of `pad_out`, and `cfg_oe_inv`=1 inverts every bit of `pad_oe`.
- R8: The enable element loads `loc_oe[oe_sel[0]]` when the top bit of `oe_sel` is 0, and `glb_oe[oe_sel[GW-1:0]]` when it is 1. It is clocked with the output element, and each lane of `pad_oe` carries its value.
- R9: The output and input mode fields use the same encoding: 00 loads the normal source, 01 loads the neighbour n-1 port (`*_from_lo`), 10 loads the neighbour n+1 port (`*_from_hi`), and 11 holds.
- R10: The input element uses `clk_i`/`ce_i`/`sr_i` only. Edges of `clk_o` never change it.
- R11: When not bypassed, `in_data` equals the stored input value `ireg_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_o | input | 1 | Clock for output and enable elements |
| ce_o | input | 1 | Clock enable for output and enable elements |
| sr_o | input | 1 | Set/reset for output and enable elements |
| clk_i | input | 1 | Clock for input element |
| ce_i | input | 1 | Clock enable for input element |
| sr_i | input | 1 | Set/reset for input element |
| grst_n | input | 1 | Global reset, active low, asynchronous |
| route_in | input | 4*DW | Four routing-bus lanes |
| msel | input | 2 | Mux lane select |
| mux_fb | output | DW | Mux result fed back to routing |
| oq_from_lo | input | DW | Output element of neighbour n-1 |
| oq_from_hi | input | DW | Output element of neighbour n+1 |
| oreg_q | output | DW | Stored output value, to neighbours |
| pad_in | input | DW | Data arriving from the pad |
| iq_from_lo | input | DW | Input element of neighbour n-1 |
| iq_from_hi | input | DW | Input element of neighbour n+1 |
| ireg_q | output | DW | Stored input value, to neighbours |
| in_data | output | DW | Input data towards routing |
| loc_oe | input | 2 | Local enable candidates |
| glb_oe | input | N_GOE | Global enable candidates |
| oe_sel | input | GW+1 | Enable source select |
| pad_out | output | DW | Data driven to the pad |
| pad_oe | output | DW | Output enable, one copy per lane |
| cfg_latch | input | 3 | 1 = latch, per element (0 in, 1 out, 2 enable) |
| cfg_init | input | 3 | Initial value per element, 1 = set |
| cfg_byp_in | input | 1 | Bypass the input element |
| cfg_byp_out | input | 1 | Bypass the output element |
| cfg_out_inv | input | 1 | Invert pad data |
| cfg_oe_inv | input | 1 | Invert pad enable |
| cfg_ckpol_o | input | 1 | Output-side clock polarity |
| cfg_cepol_o | input | 1 | Output-side enable polarity |
| cfg_srpol_o | input | 1 | Output-side set/reset polarity |
| cfg_ckpol_i | input | 1 | Input-side clock polarity |
| cfg_cepol_i | input | 1 | Input-side enable polarity |
| cfg_srpol_i | input | 1 | Input-side set/reset polarity |
| cfg_omode | input | 2 | Output element source mode |
| cfg_imode | input | 2 | Input element source mode |

## Verification
The bench builds the cell with DW=4 and N_GOE=4. With four bits per lane, the lanes A, B, C and D of the routing bus can be told apart, and an inverted value differs from every lane value. All-ones and all-zeros initial values are also distinct from the shifted-in values. With four global enables, a 3-bit select covers both local enables and a global index whose top bit is set, so the two ways of decoding the select are each exercised.

// File: rtl/mrio_cell.sv
module mrio_cell #(
  parameter int DW    = 1,
  parameter int N_GOE = 4,
  localparam int GW   = (N_GOE > 1) ? $clog2(N_GOE) : 1,
  localparam int OSW  = GW + 1
) (
  input  logic             clk_o,
  input  logic             ce_o,
  input  logic             sr_o,
  input  logic             clk_i,
  input  logic             ce_i,
  input  logic             sr_i,
  input  logic             grst_n,
  input  logic [4*DW-1:0]  route_in,
  input  logic [1:0]       msel,
  output logic [DW-1:0]    mux_fb,
  input  logic [DW-1:0]    oq_from_lo,
  input  logic [DW-1:0]    oq_from_hi,
  output logic [DW-1:0]    oreg_q,
  input  logic [DW-1:0]    pad_in,
  input  logic [DW-1:0]    iq_from_lo,
  input  logic [DW-1:0]    iq_from_hi,
  output logic [DW-1:0]    ireg_q,
  output logic [DW-1:0]    in_data,
  input  logic [1:0]       loc_oe,
  input  logic [N_GOE-1:0] glb_oe,
  input  logic [OSW-1:0]   oe_sel,
  output logic [DW-1:0]    pad_out,
  output logic [DW-1:0]    pad_oe,
  input  logic [2:0]       cfg_latch,
  input  logic [2:0]       cfg_init,
  input  logic             cfg_byp_in,
  input  logic             cfg_byp_out,
  input  logic             cfg_out_inv,
  input  logic             cfg_oe_inv,
  input  logic             cfg_ckpol_o,
  input  logic             cfg_cepol_o,
  input  logic             cfg_srpol_o,
  input  logic             cfg_ckpol_i,
  input  logic             cfg_cepol_i,
  input  logic             cfg_srpol_i,
  input  logic [1:0]       cfg_omode,
  input  logic [1:0]       cfg_imode
);
  localparam logic [1:0] M_LO = 2'b01, M_HI = 2'b10, M_HOLD = 2'b11;

  logic ck_o, ce_oa, sr_oa, ck_i, ce_ia, sr_ia, oe_src;
  logic [DW-1:0] d_in, d_out;

  assign ck_o  = clk_o ^ cfg_ckpol_o;
  assign ce_oa = ce_o ^ cfg_cepol_o;
  assign sr_oa = (sr_o ^ cfg_srpol_o) | ~grst_n;
  assign ck_i  = clk_i ^ cfg_ckpol_i;
  assign ce_ia = ce_i ^ cfg_cepol_i;
  assign sr_ia = (sr_i ^ cfg_srpol_i) | ~grst_n;

  assign mux_fb = route_in[msel*DW +: DW];
  assign oe_src = oe_sel[OSW-1] ? glb_oe[oe_sel[GW-1:0]] : loc_oe[oe_sel[0]];

  always_comb begin
    case (cfg_imode)
      M_LO:    d_in = iq_from_lo;
      M_HI:    d_in = iq_from_hi;
      default: d_in = pad_in;
    endcase
    case (cfg_omode)
      M_LO:    d_out = oq_from_lo;
      M_HI:    d_out = oq_from_hi;
      default: d_out = mux_fb;
    endcase
  end

  // element 0: input capture, 1: output drive, 2: output enable
  logic [2:0]    ck_e, ld_e, sr_e;
  logic [DW-1:0] d_e [3];
  logic [DW-1:0] q_e [3];

  assign ck_e = {ck_o, ck_o, ck_i};
  assign sr_e = {sr_oa, sr_oa, sr_ia};
  assign ld_e = {ce_oa, ce_oa & (cfg_omode != M_HOLD), ce_ia & (cfg_imode != M_HOLD)};
  assign d_e[0] = d_in;
  assign d_e[1] = d_out;
  assign d_e[2] = {DW{oe_src}};

  for (genvar k = 0; k < 3; k++) begin : g_elem
    logic          ck, sr, ld;
    logic [DW-1:0] iv, qf, ql;
    assign ck = ck_e[k];
    assign sr = sr_e[k];
    assign ld = ld_e[k];
    assign iv = {DW{cfg_init[k]}};

    always_ff @(posedge ck or posedge sr) begin
      if (sr)      qf <= iv;
      else if (ld) qf <= d_e[k];
    end

    always_latch begin
      if (sr)           ql = iv;
      else if (ck & ld) ql = d_e[k];
    end

    assign q_e[k] = cfg_latch[k] ? ql : qf;
  end

  assign ireg_q  = q_e[0];
  assign in_data = cfg_byp_in ? pad_in : q_e[0];
  assign oreg_q  = q_e[1];
  assign pad_out = (cfg_byp_out ? mux_fb : q_e[1]) ^ {DW{cfg_out_inv}};
  assign pad_oe  = q_e[2] ^ {DW{cfg_oe_inv}};

  assert_grst_init_R6: assert property (@(posedge clk_o) disable iff (grst_n)
    !grst_n |-> (oreg_q == {DW{cfg_init[1]}} && ireg_q == {DW{cfg_init[0]}}));

  assert_out_hold_R9: assert property (@(posedge ck_o) disable iff (sr_oa || cfg_latch[1])
    (cfg_omode == M_HOLD) |=> $stable(oreg_q));

  assert_out_shift_lo_R9: assert property (@(posedge ck_o) disable iff (sr_oa || cfg_latch[1])
    (cfg_omode == M_LO && ce_oa) |=> (oreg_q == $past(oq_from_lo)));

  assert_in_ce_off_R2: assert property (@(posedge ck_i) disable iff (sr_ia || cfg_latch[0])
    !ce_ia |=> $stable(ireg_q));

  assert_oe_load_R8: assert property (@(posedge ck_o) disable iff (sr_oa || cfg_latch[2])
    ce_oa |=> (pad_oe == ({DW{$past(oe_src)}} ^ {DW{cfg_oe_inv}})));
endmodule

// File: tb/test_mrio_cell.sv
module test_mrio_cell;
  localparam int DW = 4, N_GOE = 4, OSW = 3;

  logic clk = 0, run_o = 1, run_i = 1, done = 0;
  always #5 clk = ~clk;

  logic ce_o, sr_o, ce_i, sr_i, grst_n = 1;
  logic [4*DW-1:0] route_in;
  logic [1:0] msel, loc_oe, cfg_omode, cfg_imode;
  logic [DW-1:0] oq_from_lo, oq_from_hi, pad_in, iq_from_lo, iq_from_hi;
  logic [N_GOE-1:0] glb_oe;
  logic [OSW-1:0] oe_sel;
  logic [2:0] cfg_latch, cfg_init;
  logic cfg_byp_in, cfg_byp_out, cfg_out_inv, cfg_oe_inv;
  logic cfg_ckpol_o, cfg_cepol_o, cfg_srpol_o, cfg_ckpol_i, cfg_cepol_i, cfg_srpol_i;
  logic [DW-1:0] mux_fb, oreg_q, ireg_q, in_data, pad_out, pad_oe;
  int checks = 0, fails = 0;

  mrio_cell #(.DW(DW), .N_GOE(N_GOE)) i_mrio_cell (
    .clk_o(clk & run_o), .ce_o, .sr_o, .clk_i(clk & run_i), .ce_i, .sr_i, .grst_n,
    .route_in, .msel, .mux_fb, .oq_from_lo, .oq_from_hi, .oreg_q,
    .pad_in, .iq_from_lo, .iq_from_hi, .ireg_q, .in_data,
    .loc_oe, .glb_oe, .oe_sel, .pad_out, .pad_oe,
    .cfg_latch, .cfg_init, .cfg_byp_in, .cfg_byp_out, .cfg_out_inv, .cfg_oe_inv,
    .cfg_ckpol_o, .cfg_cepol_o, .cfg_srpol_o, .cfg_ckpol_i, .cfg_cepol_i, .cfg_srpol_i,
    .cfg_omode, .cfg_imode);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pe(); @(posedge clk); #1; endtask
  task automatic ne(); @(negedge clk); #1; endtask

  task automatic begin_reset();
    ne();
    grst_n = 0;
    run_o = 1; run_i = 1;
    ce_o = 1; sr_o = 0; ce_i = 1; sr_i = 0;
    route_in = 16'hDCBA; msel = 0; loc_oe = 0; glb_oe = 0; oe_sel = 0;
    oq_from_lo = 0; oq_from_hi = 0; pad_in = 0; iq_from_lo = 0; iq_from_hi = 0;
    cfg_latch = 0; cfg_init = 0; cfg_byp_in = 0; cfg_byp_out = 0;
    cfg_out_inv = 0; cfg_oe_inv = 0; cfg_omode = 0; cfg_imode = 0;
    cfg_ckpol_o = 0; cfg_cepol_o = 0; cfg_srpol_o = 0;
    cfg_ckpol_i = 0; cfg_cepol_i = 0; cfg_srpol_i = 0;
  endtask

  task automatic end_reset();
    repeat (2) @(posedge clk);
    ne();
    grst_n = 1;
  endtask

  task automatic t_reset();
    begin_reset();
    cfg_init = 3'b101;
    repeat (2) pe();
    chk("R6 grst out init", oreg_q, 4'h0);
    chk("R6 grst in init", ireg_q, 4'hF);
    chk("R6 grst oe init", pad_oe, 4'hF);
    chk("R11 in_data follows ireg", in_data, 4'hF);
    end_reset();
  endtask

  task automatic t_mux();
    for (int s = 0; s < 4; s++) begin
      msel = 2'(s); #1;
      chk("R1 mux lane", mux_fb, 4'hA + 4'(s));
    end
  endtask

  task automatic t_flop();
    begin_reset(); msel = 2; end_reset();
    chk("R2 before edge", pad_out, 4'h0);
    pe(); chk("R2 load on edge", pad_out, 4'hC);
    chk("R2 oreg", oreg_q, 4'hC);
    ce_o = 0; msel = 3; pe();
    chk("R2 ce off hold", pad_out, 4'hC);
    ce_o = 1; pe();
    chk("R2 ce on load", pad_out, 4'hD);
  endtask

  task automatic t_pol();
    begin_reset(); cfg_ckpol_o = 1; msel = 0; end_reset();
    chk("R5 no load yet", pad_out, 4'h0);
    pe(); chk("R5 rising edge ignored", pad_out, 4'h0);
    ne(); chk("R5 falling edge loads", pad_out, 4'hA);
    cfg_cepol_o = 1; msel = 1; ne();
    chk("R5 ce active low, high holds", pad_out, 4'hA);
    ce_o = 0; ne();
    chk("R5 ce active low loads", pad_out, 4'hB);
  endtask

  task automatic t_latch();
    begin_reset(); cfg_latch = 3'b010; msel = 0; end_reset();
    chk("R3 closed at low", pad_out, 4'h0);
    pe(); chk("R3 open at high", pad_out, 4'hA);
    msel = 1; #1; chk("R3 transparent", pad_out, 4'hB);
    ne(); msel = 2; #1; chk("R3 holds at low", pad_out, 4'hB);
    pe(); chk("R3 reopens", pad_out, 4'hC);
  endtask

  task automatic t_sr();
    begin_reset(); end_reset();
    ne(); run_o = 0; cfg_init = 3'b010; sr_o = 1; #1;
    chk("R6 async set no clock", oreg_q, 4'hF);
    ne(); run_o = 1; msel = 1;
    pe(); chk("R6 set overrides ce", oreg_q, 4'hF);
    sr_o = 0; pe(); chk("R6 release then load", oreg_q, 4'hB);
    cfg_srpol_o = 1; #1; chk("R5 R6 active-low set", oreg_q, 4'hF);
    sr_o = 1; pe(); chk("R5 active-low released", oreg_q, 4'hB);
  endtask

  task automatic t_bypass();
    begin_reset(); end_reset();
    pe(); ce_o = 0; cfg_byp_out = 1; msel = 2; #1;
    chk("R4 out bypass", pad_out, 4'hC);
    chk("R4 oreg kept", oreg_q, 4'hA);
    cfg_byp_in = 1; pad_in = 4'h6; #1;
    chk("R4 in bypass", in_data, 4'h6);
    pad_in = 4'h9; #1;
    chk("R4 in bypass follow", in_data, 4'h9);
  endtask

  task automatic t_inv();
    begin_reset(); msel = 1; end_reset();
    pe(); chk("R7 plain", pad_out, 4'hB);
    cfg_out_inv = 1; #1; chk("R7 out inverted", pad_out, 4'h4);
    cfg_oe_inv = 1; #1; chk("R7 oe inverted", pad_oe, 4'hF);
  endtask

  task automatic t_oe();
    begin_reset(); end_reset();
    loc_oe = 2'b01; oe_sel = 3'b000; pe(); chk("R8 local 0", pad_oe, 4'hF);
    oe_sel = 3'b001; pe(); chk("R8 local 1", pad_oe, 4'h0);
    glb_oe = 4'b0100; oe_sel = 3'b110; pe(); chk("R8 global 2", pad_oe, 4'hF);
    oe_sel = 3'b111; pe(); chk("R8 global 3", pad_oe, 4'h0);
  endtask

  task automatic t_shift();
    begin_reset(); end_reset();
    cfg_omode = 2'b01; oq_from_lo = 4'h9; pe(); chk("R9 out from n-1", oreg_q, 4'h9);
    cfg_omode = 2'b10; oq_from_hi = 4'h6; pe(); chk("R9 out from n+1", oreg_q, 4'h6);
    cfg_omode = 2'b11; msel = 3; pe(); pe(); chk("R9 out hold", oreg_q, 4'h6);
    cfg_omode = 2'b00; pe(); chk("R9 out normal", oreg_q, 4'hD);
    cfg_imode = 2'b01; iq_from_lo = 4'h3; pe(); chk("R9 in from n-1", ireg_q, 4'h3);
    chk("R11 in_data stored", in_data, 4'h3);
    cfg_imode = 2'b10; iq_from_hi = 4'hC; pe(); chk("R9 in from n+1", ireg_q, 4'hC);
    cfg_imode = 2'b11; pad_in = 4'h1; pe(); chk("R9 in hold", ireg_q, 4'hC);
    cfg_imode = 2'b00; pad_in = 4'h5; pe(); chk("R9 in normal", ireg_q, 4'h5);
  endtask

  task automatic t_iclk();
    begin_reset(); pad_in = 4'h5; end_reset();
    pe(); chk("R10 input loads", ireg_q, 4'h5);
    ne(); run_i = 0; pad_in = 4'h7; msel = 2;
    pe(); pe();
    chk("R10 clk_o leaves input", ireg_q, 4'h5);
    chk("R10 output still clocks", oreg_q, 4'hC);
    ne(); run_i = 1;
    pe(); chk("R10 own clock loads", ireg_q, 4'h7);
    ce_i = 0; pad_in = 4'h8; pe();
    chk("R2 R10 input ce off", ireg_q, 4'h7);
  endtask

  initial begin
    t_reset();
    t_mux();
    t_flop();
    t_pol();
    t_latch();
    t_sr();
    t_bypass();
    t_inv();
    t_oe();
    t_shift();
    t_iclk();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule